// File: doc/BRIEF.md
# Transmit Queue Halt and Purge Controller

This block holds outgoing frame bytes in a small ring buffer. The host side pushes bytes into it, and the MAC side pulls them out. Every stored byte carries an end-of-frame marker, so the block always knows where one frame stops and the next begins. A four-bit control register enables the transmitter and the MAC path. The same register lets the host ask for an orderly halt and for a purge of the queue.

A halt never cuts a frame short. Bytes of a frame already started keep flowing to the MAC, and no new frame starts. The halt finishes only when the MAC has returned one status for every frame it has taken. When the halt finishes, the hardware clears both the halt bit and the transmitter-on bit and raises a one-cycle interrupt.

The host may then purge the queue, which resets both ring pointers. It may instead restart with the queued frames still in place.

Top module: `txq_halt_ctrl`

## Requirements
- R1: After reset the control register reads 0, `rd_valid`, `wr_full` and `halt_done_irq` are low, and the queue is empty.
- R2: Bytes reach the read port in the order they were pushed, each with the end-of-frame flag it was pushed with. A byte is consumed on a clock edge where `rd_valid` and `rd_ready` are both high.
- R3: A new frame is offered only when the transmitter-on bit (bit 0) and the MAC enable bit (bit 2) are 1 and the halt bit (bit 1) is 0. After an end-of-frame byte is consumed under a pending halt, `rd_valid` stays low even if further frames are queued.
- R4: Once a frame has started, its remaining bytes are still offered after a halt request.
- R5: Writing 1 to bit 1 sets the halt bit, and writing 0 to it has no effect. The halt completes on the edge at which no frame is partly sent and every consumed end-of-frame has been matched by a `tx_stat_valid` pulse. On that edge bits 1 and 0 clear. With nothing outstanding, this is the edge after the halt bit is set.
- R6: Each halt completion gives `halt_done_irq` high for exactly one cycle, in the cycle after the bits clear.
- R7: The purge bit (bit 3) reads 1 for one cycle after it is written and then clears by itself. If bit 0 is 0 at that point, both pointers return to their reset value and the queue becomes empty.
- R8: A purge written while bit 0 is 1 is ignored: the bit still self-clears and the queued data remains.
- R9: Without a purge, the queued frames resume after a halt only once bits 0 and 2 are both 1 again.
- R10: `wr_full` is high when DEPTH entries are held, and a push while full is dropped.
- R11: A push in the same cycle as an executing purge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Write value: bit0 transmitter on, bit1 halt, bit2 MAC enable, bit3 purge |
| cfg_rdata | output | 4 | Current control register |
| wr_en | input | 1 | Push one byte |
| wr_data | input | DW | Byte to push |
| wr_eof | input | 1 | Pushed byte ends a frame |
| wr_full | output | 1 | Queue holds DEPTH entries |
| rd_valid | output | 1 | Head byte is offered to the MAC |
| rd_data | output | DW | Head byte |
| rd_eof | output | 1 | Head byte ends a frame |
| rd_ready | input | 1 | MAC takes the offered byte |
| tx_stat_valid | input | 1 | MAC returns status for one frame |
| halt_done_irq | output | 1 | One-cycle halt completion pulse |

## Verification
Two events can land on the same clock edge: a purge being carried out and a host push. The bench sets the purge bit while the transmitter is off, then drives a push in exactly the cycle the purge executes. The push must be lost. To judge this, the bench re-enables transmission and expects `rd_valid` to stay low. It then pushes a fresh byte and expects to see that byte alone at the head. A second coincidence is tested as well: the last frame's status arrives on the same edge that completes the halt. The bench expects the halt and transmitter-on bits to be clear and the interrupt to be high right after that status pulse.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Control register layout: bit0 xon, bit1 halt, bit2 mac_en, bit3 purge
  typedef struct packed {
    logic purge;
    logic mac_en;
    logic halt;
    logic xon;
  } txq_cfg_t;

  localparam int CFG_W = 4;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [EW-1:0] push_word,
  input  logic          pop_req,
  input  logic          flush,
  output logic [EW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [EW-1:0] mem [DEPTH];
  logic [LW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  function automatic logic [LW-1:0] ring_level(input logic [LW-1:0] w, input logic [LW-1:0] r);
    return w - r;
  endfunction

  function automatic logic [LW-1:0] ring_bump(input logic [LW-1:0] p);
    return p + LW'(1);
  endfunction

  assign level   = ring_level(wp, rp);
  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;
  assign head    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp[AW-1:0]] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_ok) wp <= ring_bump(wp);
      if (pop_ok)  rp <= ring_bump(rp);
    end
  end
endmodule

// File: rtl/txq_frame_trk.sv
module txq_frame_trk #(
  parameter int MAX_PEND = 8,
  localparam int PW      = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_fire,
  input  logic          pop_eof,
  input  logic          stat_valid,
  input  logic          flush,
  input  logic          halt_q,
  output logic          in_frame,
  output logic [PW-1:0] pending,
  output logic          halt_done
);
  logic          in_frame_nx;
  logic [PW-1:0] pend_nx;

  function automatic logic [PW-1:0] pend_step(input logic [PW-1:0] cur,
                                               input logic inc, input logic dec);
    if (inc && !dec && cur != PW'(MAX_PEND)) return cur + PW'(1);
    if (dec && !inc && cur != '0)            return cur - PW'(1);
    return cur;
  endfunction

  always_comb begin
    if (flush)         in_frame_nx = 1'b0;
    else if (pop_fire) in_frame_nx = !pop_eof;
    else               in_frame_nx = in_frame;
  end

  assign pend_nx   = pend_step(pending, pop_fire && pop_eof, stat_valid);
  assign halt_done = halt_q && !in_frame_nx && (pend_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      pending  <= '0;
    end else begin
      in_frame <= in_frame_nx;
      pending  <= pend_nx;
    end
  end
endmodule

// File: rtl/txq_cfg.sv
module txq_cfg
  import txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             halt_done,
  output txq_cfg_t         cfg_q,
  output logic             purge_fire,
  output logic             done_irq
);
  txq_cfg_t wd;
  assign wd         = txq_cfg_t'(cfg_wdata);
  assign purge_fire = cfg_q.purge && !cfg_q.xon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq    <= halt_done;
      cfg_q.purge <= cfg_wr && wd.purge;
      if (cfg_wr) begin
        cfg_q.xon    <= wd.xon;
        cfg_q.mac_en <= wd.mac_en;
      end
      if (cfg_wr && wd.halt) cfg_q.halt <= 1'b1;
      if (halt_done) begin
        cfg_q.halt <= 1'b0;
        cfg_q.xon  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txq_halt_ctrl.sv
module txq_halt_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int MAX_PEND = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int LW      = AW + 1,
  localparam int EW      = DW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_eof,
  output logic             wr_full,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             rd_eof,
  input  logic             rd_ready,
  input  logic             tx_stat_valid,
  output logic             halt_done_irq
);
  txq_cfg_t      cfg_q;
  logic          purge_fire, halt_done, in_frame, pop_fire;
  logic          fifo_empty, may_start;
  logic [EW-1:0] head;
  logic [LW-1:0] fifo_level;

  txq_cfg u_cfg (
    .clk, .rst_n, .cfg_wr, .cfg_wdata,
    .halt_done (halt_done),
    .cfg_q     (cfg_q),
    .purge_fire(purge_fire),
    .done_irq  (halt_done_irq)
  );

  txq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk, .rst_n,
    .push_req (wr_en),
    .push_word({wr_eof, wr_data}),
    .pop_req  (pop_fire),
    .flush    (purge_fire),
    .head     (head),
    .empty    (fifo_empty),
    .full     (wr_full),
    .level    (fifo_level)
  );

  txq_frame_trk #(.MAX_PEND(MAX_PEND)) u_trk (
    .clk, .rst_n,
    .pop_fire  (pop_fire),
    .pop_eof   (head[DW]),
    .stat_valid(tx_stat_valid),
    .flush     (purge_fire),
    .halt_q    (cfg_q.halt),
    .in_frame  (in_frame),
    .pending   (),
    .halt_done (halt_done)
  );

  assign may_start = cfg_q.xon && cfg_q.mac_en && !cfg_q.halt;
  assign rd_valid  = !fifo_empty && (in_frame || may_start);
  assign pop_fire  = rd_valid && rd_ready && !purge_fire;
  assign rd_data   = head[DW-1:0];
  assign rd_eof    = head[DW];
  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/txq_halt_chk.sv
module txq_halt_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cfg_rdata,
  input logic          cfg_wr,
  input logic [3:0]    cfg_wdata,
  input logic          wr_en,
  input logic          rd_valid,
  input logic          in_frame,
  input logic          halt_done_irq,
  input logic          purge_fire,
  input logic          fifo_empty,
  input logic          pop_fire,
  input logic [LW-1:0] fifo_level
);
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done_irq |=> !halt_done_irq);
  // R5
  irq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done_irq |-> (cfg_rdata[1:0] == 2'b00));
  // R3
  frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !in_frame) |-> (cfg_rdata[0] && cfg_rdata[2] && !cfg_rdata[1]));
  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1] && in_frame) |=> cfg_rdata[1]);
  // R7
  purge_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_fire |=> fifo_empty);
  // R7
  purge_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && !(cfg_wr && cfg_wdata[3])) |=> !cfg_rdata[3]);
  // R8
  purge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && cfg_rdata[0] && !pop_fire && !wr_en) |=> $stable(fifo_level));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
endmodule

bind txq_halt_ctrl txq_halt_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rdata    (cfg_rdata),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .wr_en        (wr_en),
  .rd_valid     (rd_valid),
  .in_frame     (in_frame),
  .halt_done_irq(halt_done_irq),
  .purge_fire   (purge_fire),
  .fifo_empty   (fifo_empty),
  .pop_fire     (pop_fire),
  .fifo_level   (fifo_level)
);

// File: tb/sim_txq_halt_ctrl.sv
`timescale 1ns/1ps
module sim_txq_halt_ctrl;
  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [3:0]    cfg_wdata = '0;
  logic [3:0]    cfg_rdata;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_eof = 1'b0;
  logic          wr_full, rd_valid, rd_eof, halt_done_irq;
  logic [DW-1:0] rd_data;
  logic          rd_ready = 1'b0;
  logic          tx_stat_valid = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  txq_halt_ctrl #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

  // {eof, data}: three frames of 3, 4 and 3 bytes
  localparam logic [8:0] VEC [10] = '{
    9'h011, 9'h012, 9'h113,
    9'h021, 9'h022, 9'h023, 9'h124,
    9'h031, 9'h032, 9'h133
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cfgw(input logic [3:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; cyc(); cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic e);
    wr_en = 1'b1; wr_data = d; wr_eof = e; cyc(); wr_en = 1'b0;
  endtask

  task automatic stat();
    tx_stat_valid = 1'b1; cyc(); tx_stat_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 cfg", 16'(cfg_rdata), 16'h0);
    chk("R1 rd_valid", 16'(rd_valid), 16'h0);
    chk("R1 wr_full", 16'(wr_full), 16'h0);
    chk("R1 irq", 16'(halt_done_irq), 16'h0);

    // Vector walk: push while off, then drain in order (R2, R3)
    for (int i = 0; i < 10; i++) push(VEC[i][7:0], VEC[i][8]);
    chk("R3 off gate", 16'(rd_valid), 16'h0);
    cfgw(4'b0101);
    rd_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      chk("R2 valid", 16'(rd_valid), 16'h1);
      chk("R2 word", 16'({rd_eof, rd_data}), 16'(VEC[i]));
      cyc();
    end
    rd_ready = 1'b0;
    chk("R2 drained", 16'(rd_valid), 16'h0);
    stat(); stat(); stat();

    // R5 idle halt completes on next edge, R6 single pulse
    cfgw(4'b0111);
    chk("R5 halt set", 16'(cfg_rdata), 16'h7);
    chk("R6 no early irq", 16'(halt_done_irq), 16'h0);
    cyc();
    chk("R5 idle done", 16'(cfg_rdata), 16'h4);
    chk("R6 irq high", 16'(halt_done_irq), 16'h1);
    cyc();
    chk("R6 irq one cycle", 16'(halt_done_irq), 16'h0);

    // Halt during a frame (R4, R3, R5)
    cfgw(4'b0101);
    push(8'hA0, 0); push(8'hA1, 0); push(8'hA2, 0); push(8'hA3, 1);
    push(8'hB0, 0); push(8'hB1, 1);
    rd_ready = 1'b1; cyc(); cyc(); rd_ready = 1'b0;
    cfgw(4'b0111);
    rd_ready = 1'b1;
    chk("R4 mid frame", 16'({rd_valid, rd_eof, rd_data}), 16'h2A2);
    cyc();
    chk("R4 last byte", 16'({rd_valid, rd_eof, rd_data}), 16'h3A3);
    cyc();
    chk("R3 no new frame", 16'(rd_valid), 16'h0);
    rd_ready = 1'b0;
    cyc(); cyc(); cyc();
    chk("R5 waits status", 16'(cfg_rdata), 16'h7);
    chk("R5 no irq yet", 16'(halt_done_irq), 16'h0);
    stat();
    chk("R5 done on status", 16'(cfg_rdata), 16'h4);
    chk("R6 irq after status", 16'(halt_done_irq), 16'h1);

    // R9 resume queued frame only with both enables
    cfgw(4'b0001);
    chk("R9 en clear", 16'(rd_valid), 16'h0);
    cfgw(4'b0101);
    chk("R9 resume", 16'({rd_valid, rd_eof, rd_data}), 16'h2B0);
    rd_ready = 1'b1; cyc(); cyc(); rd_ready = 1'b0;
    stat();
    chk("R9 drained", 16'(rd_valid), 16'h0);

    // R8 purge ignored while on
    push(8'hC0, 0); push(8'hC1, 1);
    cfgw(4'b1101);
    chk("R8 purge bit", 16'(cfg_rdata), 16'hD);
    cyc();
    chk("R8 self clear", 16'(cfg_rdata), 16'h5);
    chk("R8 data kept", 16'({rd_valid, rd_eof, rd_data}), 16'h2C0);
    cfgw(4'b0111);
    cyc();
    chk("R5 stop again", 16'(cfg_rdata), 16'h4);

    // R7 purge while stopped, R11 push in same cycle dropped
    cfgw(4'b1100);
    chk("R7 purge bit", 16'(cfg_rdata), 16'hC);
    push(8'hD0, 1);
    chk("R7 self clear", 16'(cfg_rdata), 16'h4);
    cfgw(4'b0101);
    chk("R7 R11 empty", 16'(rd_valid), 16'h0);
    push(8'h5A, 1);
    chk("R11 fresh head", 16'({rd_valid, rd_eof, rd_data}), 16'h35A);

    // R10 full and overflow
    for (int i = 0; i < DEPTH - 1; i++) push(8'(8'h40 + i), 1);
    chk("R10 full", 16'(wr_full), 16'h1);
    push(8'hEE, 1);
    rd_ready = 1'b1;
    chk("R10 first", 16'({rd_valid, rd_eof, rd_data}), 16'h35A);
    cyc();
    for (int i = 0; i < DEPTH - 1; i++) begin
      chk("R10 order", 16'({rd_valid, rd_eof, rd_data}), 16'(12'h300 + 12'h40 + i));
      cyc();
    end
    chk("R10 overflow dropped", 16'(rd_valid), 16'h0);
    rd_ready = 1'b0;

    summary();
    $finish;
  end
endmodule